// File: doc/BRIEF.md
# Base-and-Bound Address Relocation Unit

This unit converts a program-relative word address into a physical memory address. Every program works in a private window of contiguous words that starts at logical address zero. Two registers describe the window: a base that holds the window's physical start, and a limit that holds its length in words. Each request is first compared against the limit. A request that passes has the base added to it and goes out as a physical access. A request that fails, or whose sum would not fit in the address width, raises a fault and produces no access.

The operating system moves a program in memory by rewriting the base register. The program's own addresses stay the same. Only a caller in supervisor mode may change the base or limit registers, or clear the sticky fault flag. A configuration write made in user mode is dropped and raises a one-cycle privilege-violation flag. All outputs are registered and appear one clock after the request.

Top module: `addr_reloc`

## Requirements
- R1: After a synchronous reset, base and limit are 0 and every output (phys_addr, phys_valid, phys_write, acc_fault, fault_sticky, priv_viol) is 0.
- R2: A request with logical address a < limit, and with base + a representable in AW bits, gives phys_valid=1, phys_addr=base+a and phys_write=req_write on the next clock.
- R3: A request with a ≥ limit gives acc_fault=1, phys_valid=0, phys_write=0 and phys_addr=0 on the next clock.
- R4: While limit is 0, every request faults.
- R5: A request whose sum base + a carries out of AW bits faults, even when a < limit.
- R6: With priv=1, cfg_we writes cfg_data into the base register (cfg_sel=0) or the limit register (cfg_sel=1). A request in the same cycle still uses the old values, and requests from the next cycle use the new ones.
- R7: With priv=0, cfg_we leaves base and limit unchanged and sets priv_viol to 1 for exactly the next cycle.
- R8: fault_sticky goes to 1 on the clock after any faulting request. It stays 1 until fault_clr is asserted with priv=1. fault_clr with priv=0 has no effect.
- R9: When a faulting request and a supervisor fault_clr fall in the same cycle, fault_sticky stays 1.
- R10: A cycle without req_valid gives phys_valid=0 and acc_fault=0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Logical (program-relative) word address |
| priv | input | 1 | Supervisor mode flag |
| cfg_we | input | 1 | Write strobe for the base/limit registers |
| cfg_sel | input | 1 | Register select: 0 = base, 1 = limit |
| cfg_data | input | AW | Value to load into the selected register |
| fault_clr | input | 1 | Clear the sticky fault flag (honoured only when priv=1) |
| phys_addr | output | AW | Physical address; 0 when no legal access |
| phys_valid | output | 1 | Legal access issued |
| phys_write | output | 1 | Issued access is a write |
| acc_fault | output | 1 | The previous cycle's request faulted |
| fault_sticky | output | 1 | Fault seen since the last supervisor clear |
| priv_viol | output | 1 | A user-mode configuration write was dropped |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a supervisor configuration write arrives together with a request. The bench drives both in one cycle and expects the physical address to be built from the old base, then the new base one request later. In the second, a faulting request arrives together with a supervisor clear of the sticky flag. The bench expects the flag to remain set after that cycle and to drop only after a clear that has no fault beside it. A reference model in the bench keeps its own copy of base, limit and the sticky flag, and it predicts every registered output for every cycle.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          priv,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q,
  output logic          viol_q
);
  import reloc_pkg::*;

  logic     sup_wr;
  cfg_sel_e sel;

  assign sup_wr = cfg_we && priv;
  assign sel    = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= cfg_we && !priv;
      if (sup_wr && sel == SEL_BASE)  base_q  <= cfg_data;
      if (sup_wr && sel == SEL_LIMIT) limit_q <= cfg_data;
    end
  end

  AST_USER_CFG_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !priv) |=> ($stable(base_q) && $stable(limit_q) && viol_q)); // R7
  AST_SUP_CFG_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && priv && cfg_sel) |=> (limit_q == $past(cfg_data))); // R6
endmodule

// File: rtl/reloc_check.sv
module reloc_check #(
  parameter int AW = 18
) (
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          legal,
  output logic          fault,
  output logic [AW-1:0] phys
);
  localparam int SW = AW + 1;

  logic [SW-1:0] sum;
  logic          in_range;
  logic          no_carry;

  always_comb begin
    sum      = {1'b0, base} + {1'b0, req_addr};
    in_range = req_addr < limit;
    no_carry = !sum[SW-1];
    legal    = req_valid && in_range && no_carry;
    fault    = req_valid && !(in_range && no_carry);
    phys     = legal ? sum[AW-1:0] : '0;
  end
endmodule

// File: rtl/reloc_fault.sv
module reloc_fault (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic priv,
  output logic sticky_q
);
  always_ff @(posedge clk) begin
    if (rst)               sticky_q <= 1'b0;
    else if (set)          sticky_q <= 1'b1;
    else if (clr && priv)  sticky_q <= 1'b0;
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    set |=> sticky_q); // R9
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && !(clr && priv)) |=> sticky_q); // R8
endmodule

// File: rtl/addr_reloc.sv
module addr_reloc #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          priv,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          fault_clr,
  output logic [AW-1:0] phys_addr,
  output logic          phys_valid,
  output logic          phys_write,
  output logic          acc_fault,
  output logic          fault_sticky,
  output logic          priv_viol
);
  logic [AW-1:0] base_q, limit_q, phys_c;
  logic          legal_c, fault_c;

  reloc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .priv(priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .base_q(base_q), .limit_q(limit_q), .viol_q(priv_viol)
  );

  reloc_check #(.AW(AW)) u_check (
    .req_valid(req_valid), .req_addr(req_addr), .base(base_q), .limit(limit_q),
    .legal(legal_c), .fault(fault_c), .phys(phys_c)
  );

  reloc_fault u_fault (
    .clk(clk), .rst(rst), .set(fault_c), .clr(fault_clr), .priv(priv),
    .sticky_q(fault_sticky)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      phys_valid <= 1'b0;
      phys_write <= 1'b0;
      acc_fault  <= 1'b0;
    end else begin
      phys_addr  <= phys_c;
      phys_valid <= legal_c;
      phys_write <= legal_c && req_write;
      acc_fault  <= fault_c;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!phys_valid && !acc_fault)); // R10
  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && limit_q == '0) |=> (acc_fault && !phys_valid)); // R4
  AST_BLOCKED_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> (phys_addr == '0 && !phys_write)); // R3
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= limit_q) |=> acc_fault); // R3
  AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> fault_sticky); // R8
endmodule

// File: tb/test_addr_reloc.sv
module test_addr_reloc;
  localparam int AW = 18;
  localparam int MAXV = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, priv = 0, cfg_we = 0, cfg_sel = 0, fault_clr = 0;
  logic [AW-1:0] req_addr = '0, cfg_data = '0;
  logic [AW-1:0] phys_addr;
  logic phys_valid, phys_write, acc_fault, fault_sticky, priv_viol;

  always #4 clk = ~clk;

  addr_reloc #(.AW(AW)) i_addr_reloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .priv(priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .fault_clr(fault_clr), .phys_addr(phys_addr),
    .phys_valid(phys_valid), .phys_write(phys_write), .acc_fault(acc_fault),
    .fault_sticky(fault_sticky), .priv_viol(priv_viol)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic valid, write, fault, sticky, viol;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  logic running = 1'b0;

  int m_base = 0, m_limit = 0;
  logic m_sticky = 1'b0;

  task automatic step(input logic rv, input logic rw, input int a, input logic pr,
                      input logic cwe, input logic csel, input int cd,
                      input logic clr, input string tag);
    exp_t e;
    logic legal;
    @(negedge clk);
    req_valid = rv; req_write = rw; req_addr = a[AW-1:0]; priv = pr;
    cfg_we = cwe; cfg_sel = csel; cfg_data = cd[AW-1:0]; fault_clr = clr;
    legal = rv && (a < m_limit) && (m_base + a <= MAXV);
    e.valid  = legal;
    e.write  = legal && rw;
    e.addr   = legal ? AW'(m_base + a) : '0;
    e.fault  = rv && !legal;
    e.viol   = cwe && !pr;
    if (e.fault) m_sticky = 1'b1;
    else if (clr && pr) m_sticky = 1'b0;
    e.sticky = m_sticky;
    if (cwe && pr) begin
      if (csel) m_limit = cd; else m_base = cd;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    if (running && exp_q.size() > 0) begin
      exp_t e, g;
      string t;
      #2;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {phys_addr, phys_valid, phys_write, acc_fault, fault_sticky, priv_viol};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL %s: got addr=%h v=%b w=%b f=%b s=%b pv=%b exp addr=%h v=%b w=%b f=%b s=%b pv=%b",
                 t, g.addr, g.valid, g.write, g.fault, g.sticky, g.viol,
                 e.addr, e.valid, e.write, e.fault, e.sticky, e.viol);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if ({phys_addr, phys_valid, phys_write, acc_fault, fault_sticky, priv_viol} !== '0) begin
      errors++;
      $display("FAIL R1: got nonzero outputs after reset exp all zero");
    end
    running = 1'b1;
    // R4: limit 0 after reset, every request faults
    step(1, 0, 5, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    // R8: supervisor clear
    step(0, 0, 0, 1, 0, 0, 0, 1, "R8");
    // R6: supervisor sets limit
    step(0, 0, 0, 1, 1, 1, 1000, 0, "R6");
    // R7: user writes ignored
    step(0, 0, 0, 0, 1, 0, 100, 0, "R7");
    step(0, 0, 0, 0, 1, 1, 0, 0, "R7");
    step(1, 1, 5, 0, 0, 0, 0, 0, "R7");
    // R6: base write in same cycle as request uses old base
    step(1, 0, 7, 1, 1, 0, 100, 0, "R6");
    step(1, 0, 7, 0, 0, 0, 0, 0, "R6");
    // R2: legal reads and writes
    step(1, 1, 999, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3: out of range
    step(1, 1, 1000, 0, 0, 0, 0, 0, "R3");
    step(1, 0, MAXV, 0, 0, 0, 0, 0, "R3");
    // R8: user clear ignored, then supervisor clear
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R8");
    // R9: fault and supervisor clear in same cycle
    step(1, 0, 2000, 1, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R9");
    // R5: carry out of address width
    step(0, 0, 0, 1, 1, 0, MAXV - 15, 0, "R5");
    step(0, 0, 0, 1, 1, 1, MAXV, 0, "R5");
    step(1, 1, 15, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 16, 0, 0, 0, 0, 0, "R5");
    // R10: idle cycles
    idle("R10");
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule